// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This block is the bit-manipulation datapath of a small in-order 32-bit core. The issue stage presents a decoded operation code, three source operands (`rs1_i`, `rs2_i`, `rs3_i`) and an immediate, and raises `start_i`. `start_i` and the operands stay unchanged until `done_o` is seen. The block returns a 32-bit `result_o`, which is valid in any cycle where `done_o` is high.

Most operations finish in the cycle they start: the negated logic ops, the single-bit ops, and generalized reverse / or-combine. Rotates and the three-operand operations (conditional move, bitwise mix, funnel shifts) take two cycles.

- These two-cycle ops share one barrel shifter. The shifter works on one operand per cycle.
- A one-bit flag, registered in the first cycle of a three-operand op, is the only signal that routes the third operand onto the shifter input in the second cycle.
- The first cycle's partial term is kept in a register and ORed with the second cycle's term.

Generalized reverse and or-combine each have their own permutation network.

A build-time level parameter selects the variant. The balanced level has every group listed here. The core level drops the three-operand group: those codes behave like unassigned codes.

Top module: `bmu_unit`

## Requirements
- R1: Codes 11 (rotate right by `rs2_i[4:0]`), 12 (rotate right by `imm_i[4:0]`), 13 (rotate left by `rs2_i[4:0]`) and, at the balanced level, codes 14 to 18 complete in two cycles. With `start_i` held, `done_o` is low in the first cycle and high in the second.
- R2: Every other code, with `start_i` high and `flush_i` low, raises `done_o` in the same cycle.
- R3: While `flush_i` is high, `done_o` is low. After a flush, and after any `done_o`, the next cycle of a two-cycle op counts as its first cycle.
- R4: Code 7 (control `rs2_i[4:0]`) and code 8 (control `imm_i[4:0]`) apply a generalized reverse to `rs1_i`. For each set control bit k, taken in the order k = 0 to 4, adjacent blocks of 2^k bits are swapped.
- R5: Code 9 (control `rs2_i[4:0]`) and code 10 (control `imm_i[4:0]`) work like R4, except that each stage ORs every block with its partner instead of swapping it. Every set bit of `rs1_i` is therefore still set in the result.
- R6: Rotates use the amount in the low 5 bits only: the upper bits of `rs2_i`, and `imm_i[5]`, are ignored. An amount of 0 returns `rs1_i`.
- R7: Code 14 returns `rs1_i` when `rs2_i` is nonzero and `rs3_i` otherwise. Code 15 returns `(rs1_i & rs2_i) | (rs3_i & ~rs2_i)`.
- R8: Code 16 (left) and code 17 (right) funnel-shift by s = `rs2_i[5:0]`; code 18 is the right funnel shift with s = `imm_i[5:0]`. Let A = `rs1_i` and B = `rs3_i`, and swap A and B when s ≥ 32. The left result is the upper word of {A,B} << (s mod 32). The right result is the lower word of {B,A} >> (s mod 32).
- R9: Code 0 returns `rs1_i & ~rs2_i`, code 1 returns `rs1_i | ~rs2_i`, and code 2 returns `~(rs1_i ^ rs2_i)`.
- R10: With bit index `rs2_i[4:0]` applied to `rs1_i`: code 3 sets the bit, code 4 clears it, code 5 inverts it, and code 6 returns the bit in result bit 0 with all other bits zero.
- R11: Codes 19 to 31, and codes 14 to 18 at the core level, complete in one cycle with a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush_i | input | 1 | Abandons an operation in progress |
| start_i | input | 1 | Operation request; held until done |
| op_i | input | 5 | Operation code |
| rs1_i | input | 32 | First source operand |
| rs2_i | input | 32 | Second source operand (amount, control, index, mask) |
| rs3_i | input | 32 | Third source operand |
| imm_i | input | 6 | Immediate amount or control |
| result_o | output | 32 | Operation result |
| done_o | output | 1 | Result valid this cycle |

## Verification
The bench builds two copies at the default 32-bit width: one at the balanced level and one at the core level. The balanced copy is swept exhaustively over every permutation control word for all four permutation codes, and over every rotate amount and every funnel amount 0 to 63 (this covers 0, 31, 32 and 63). It also covers all-zero and all-one data, every single-bit index, and flushes in both cycles of a two-cycle op. The core copy receives the same stimulus, which shows that the three-operand codes collapse to single-cycle zero results at that level.

// File: rtl/bmu_pkg.sv
`timescale 1ns/1ps
package bmu_pkg;

  typedef enum logic [4:0] {
    OP_ANDN  = 5'd0,
    OP_ORN   = 5'd1,
    OP_XNOR  = 5'd2,
    OP_BSET  = 5'd3,
    OP_BCLR  = 5'd4,
    OP_BINV  = 5'd5,
    OP_BEXT  = 5'd6,
    OP_GREV  = 5'd7,
    OP_GREVI = 5'd8,
    OP_GORC  = 5'd9,
    OP_GORCI = 5'd10,
    OP_ROR   = 5'd11,
    OP_RORI  = 5'd12,
    OP_ROL   = 5'd13,
    OP_CMOV  = 5'd14,
    OP_CMIX  = 5'd15,
    OP_FSL   = 5'd16,
    OP_FSR   = 5'd17,
    OP_FSRI  = 5'd18
  } bmu_op_e;

  typedef enum logic {
    LVL_CORE     = 1'b0,
    LVL_BALANCED = 1'b1
  } bmu_level_e;

  function automatic logic op_is_rot(input logic [4:0] op);
    return (op == OP_ROR) || (op == OP_RORI) || (op == OP_ROL);
  endfunction

  function automatic logic op_is_tern(input logic [4:0] op);
    return (op == OP_CMOV) || (op == OP_CMIX) || (op == OP_FSL) ||
           (op == OP_FSR)  || (op == OP_FSRI);
  endfunction

  function automatic logic op_is_multi(input logic [4:0] op, input logic tern_en);
    return op_is_rot(op) || (tern_en && op_is_tern(op));
  endfunction

  function automatic logic op_is_known(input logic [4:0] op, input logic tern_en);
    return (op <= OP_ROL) || (tern_en && op_is_tern(op));
  endfunction

endpackage

// File: rtl/bmu_perm_net.sv
`timescale 1ns/1ps
module bmu_perm_net #(
  parameter int WIDTH   = 32,
  parameter int STAGES  = $clog2(WIDTH),
  parameter bit OR_MODE = 1'b0
) (
  input  logic [WIDTH-1:0]  data_i,
  input  logic [STAGES-1:0] ctrl_i,
  output logic [WIDTH-1:0]  data_o
);

  logic [STAGES:0][WIDTH-1:0] stage;

  assign stage[0] = data_i;

  // Each stage pairs bit b with bit b ^ 2^s; the control bit enables the stage.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      localparam int PARTNER = b ^ (1 << s);
      if (OR_MODE) begin : g_or
        assign stage[s+1][b] = ctrl_i[s] ? (stage[s][b] | stage[s][PARTNER])
                                         : stage[s][b];
      end else begin : g_swap
        assign stage[s+1][b] = ctrl_i[s] ? stage[s][PARTNER] : stage[s][b];
      end
    end
  end

  assign data_o = stage[STAGES];

endmodule

// File: rtl/bmu_shifter.sv
`timescale 1ns/1ps
module bmu_shifter #(
  parameter int WIDTH = 32,
  parameter int SH_W  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  logic [SH_W:0]    amt_i,   // 0..WIDTH; WIDTH yields zero
  input  logic             left_i,
  output logic [WIDTH-1:0] res_o
);

  logic [WIDTH-1:0] rev_in;
  logic [WIDTH-1:0] fwd;
  logic [WIDTH-1:0] shr;
  logic [WIDTH-1:0] rev_out;

  // A left shift is a right shift of the bit-reversed operand.
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign rev_in[i]  = opnd_i[WIDTH-1-i];
    assign rev_out[i] = shr[WIDTH-1-i];
  end

  always_comb begin
    fwd = left_i ? rev_in : opnd_i;
    if (amt_i[SH_W]) begin
      shr = '0;
    end else begin
      shr = fwd >> amt_i[SH_W-1:0];
    end
    res_o = left_i ? rev_out : shr;
  end

endmodule

// File: rtl/bmu_seq.sv
`timescale 1ns/1ps
module bmu_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic start_i,
  input  logic multi_i,
  input  logic tern_i,
  output logic rst_int_no,
  output logic first_o,
  output logic second_o,
  output logic tern_sel_o,
  output logic done_o
);

  logic [1:0] rst_sync_q;
  logic       phase_d, phase_q;
  logic       tern_d,  tern_q;
  logic       flag_en;

  // Reset asserts at once and leaves after two clock edges.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_no = rst_sync_q[1];

  always_comb begin
    first_o = start_i & ~flush_i & multi_i & ~phase_q;
    done_o  = start_i & ~flush_i & (~multi_i | phase_q);
    flag_en = flush_i | done_o | first_o;
    phase_d = phase_q;
    tern_d  = tern_q;
    if (flush_i || done_o) begin
      phase_d = 1'b0;
      tern_d  = 1'b0;
    end else if (first_o) begin
      phase_d = 1'b1;
      tern_d  = tern_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_int_no) begin
    if (!rst_int_no) begin
      phase_q <= 1'b0;
      tern_q  <= 1'b0;
    end else if (flag_en) begin
      phase_q <= phase_d;
      tern_q  <= tern_d;
    end
  end

  assign second_o   = phase_q;
  assign tern_sel_o = tern_q;

endmodule

// File: rtl/bmu_unit.sv
`timescale 1ns/1ps
module bmu_unit
  import bmu_pkg::*;
#(
  parameter bmu_level_e LEVEL = LVL_BALANCED,
  parameter int         WIDTH = 32,
  parameter int         SH_W  = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             start_i,
  input  logic [4:0]       op_i,
  input  logic [WIDTH-1:0] rs1_i,
  input  logic [WIDTH-1:0] rs2_i,
  input  logic [WIDTH-1:0] rs3_i,
  input  logic [SH_W:0]    imm_i,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o
);

  localparam logic       TERN_EN = (LEVEL == LVL_BALANCED);
  localparam logic [SH_W:0] FULL = (SH_W+1)'(WIDTH);

  logic             is_multi, is_tern;
  logic             rst_int_n, first, second, tern_sel;
  logic [WIDTH-1:0] opa;
  logic [SH_W-1:0]  rot_amt, fun_lo, perm_ctrl, bit_idx;
  logic             fun_swap, role_a;
  logic [SH_W:0]    sh_amt;
  logic             sh_left;
  logic [WIDTH-1:0] sh_res;
  logic [WIDTH-1:0] cur_term;
  logic [WIDTH-1:0] partial_d, partial_q;
  logic [WIDTH-1:0] grev_res, gorc_res;
  logic [WIDTH-1:0] bit_mask, single_res;

  assign is_tern  = TERN_EN && op_is_tern(op_i);
  assign is_multi = op_is_multi(op_i, TERN_EN);

  bmu_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .start_i    (start_i),
    .multi_i    (is_multi),
    .tern_i     (is_tern),
    .rst_int_no (rst_int_n),
    .first_o    (first),
    .second_o   (second),
    .tern_sel_o (tern_sel),
    .done_o     (done_o)
  );

  // Operand A steering depends on the registered flag only.
  assign opa = tern_sel ? rs3_i : rs1_i;

  // Amount sources
  always_comb begin
    rot_amt   = (op_i == OP_RORI) ? imm_i[SH_W-1:0] : rs2_i[SH_W-1:0];
    fun_swap  = (op_i == OP_FSRI) ? imm_i[SH_W]     : rs2_i[SH_W];
    fun_lo    = (op_i == OP_FSRI) ? imm_i[SH_W-1:0] : rs2_i[SH_W-1:0];
    perm_ctrl = ((op_i == OP_GREVI) || (op_i == OP_GORCI)) ? imm_i[SH_W-1:0]
                                                           : rs2_i[SH_W-1:0];
    bit_idx   = rs2_i[SH_W-1:0];
    // The operand in this cycle plays the leading role of the funnel pair.
    role_a    = (~second) ^ fun_swap;
  end

  // Shared shifter control: one operand per cycle.
  always_comb begin
    sh_left = 1'b0;
    sh_amt  = FULL;
    unique case (op_i)
      OP_ROR, OP_RORI: begin
        sh_left = second;
        sh_amt  = second ? (FULL - {1'b0, rot_amt}) : {1'b0, rot_amt};
      end
      OP_ROL: begin
        sh_left = ~second;
        sh_amt  = second ? (FULL - {1'b0, rot_amt}) : {1'b0, rot_amt};
      end
      OP_FSL: begin
        sh_left = role_a;
        sh_amt  = role_a ? {1'b0, fun_lo} : (FULL - {1'b0, fun_lo});
      end
      OP_FSR, OP_FSRI: begin
        sh_left = ~role_a;
        sh_amt  = role_a ? {1'b0, fun_lo} : (FULL - {1'b0, fun_lo});
      end
      default: begin
        sh_left = 1'b0;
        sh_amt  = FULL;
      end
    endcase
  end

  bmu_shifter #(.WIDTH(WIDTH), .SH_W(SH_W)) u_shift (
    .opnd_i (opa),
    .amt_i  (sh_amt),
    .left_i (sh_left),
    .res_o  (sh_res)
  );

  // Per-cycle term of a two-cycle op.
  always_comb begin
    unique case (op_i)
      OP_CMOV: begin
        if (second) begin
          cur_term = (rs2_i == '0) ? opa : '0;
        end else begin
          cur_term = (rs2_i != '0) ? opa : '0;
        end
      end
      OP_CMIX: cur_term = opa & (second ? ~rs2_i : rs2_i);
      default: cur_term = sh_res;
    endcase
  end

  assign partial_d = cur_term;

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      partial_q <= '0;
    end else if (first) begin
      partial_q <= partial_d;
    end
  end

  // Dedicated permutation networks
  bmu_perm_net #(.WIDTH(WIDTH), .STAGES(SH_W), .OR_MODE(1'b0)) u_grev (
    .data_i (rs1_i),
    .ctrl_i (perm_ctrl),
    .data_o (grev_res)
  );

  bmu_perm_net #(.WIDTH(WIDTH), .STAGES(SH_W), .OR_MODE(1'b1)) u_gorc (
    .data_i (rs1_i),
    .ctrl_i (perm_ctrl),
    .data_o (gorc_res)
  );

  assign bit_mask = WIDTH'(1) << bit_idx;

  always_comb begin
    unique case (op_i)
      OP_ANDN:            single_res = rs1_i & ~rs2_i;
      OP_ORN:             single_res = rs1_i | ~rs2_i;
      OP_XNOR:            single_res = ~(rs1_i ^ rs2_i);
      OP_BSET:            single_res = rs1_i | bit_mask;
      OP_BCLR:            single_res = rs1_i & ~bit_mask;
      OP_BINV:            single_res = rs1_i ^ bit_mask;
      OP_BEXT:            single_res = {{(WIDTH-1){1'b0}}, rs1_i[bit_idx]};
      OP_GREV, OP_GREVI:  single_res = grev_res;
      OP_GORC, OP_GORCI:  single_res = gorc_res;
      default:            single_res = '0;
    endcase
  end

  assign result_o = is_multi ? (partial_q | cur_term) : single_res;

endmodule

// File: rtl/bmu_unit_checker.sv
`timescale 1ns/1ps
module bmu_unit_checker
  import bmu_pkg::*;
#(
  parameter bmu_level_e LEVEL = LVL_BALANCED,
  parameter int         WIDTH = 32,
  parameter int         SH_W  = $clog2(WIDTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             start_i,
  input logic [4:0]       op_i,
  input logic [WIDTH-1:0] rs1_i,
  input logic [WIDTH-1:0] rs2_i,
  input logic [WIDTH-1:0] rs3_i,
  input logic [SH_W:0]    imm_i,
  input logic [WIDTH-1:0] result_o,
  input logic             done_o
);

  localparam logic TERN_EN = (LEVEL == LVL_BALANCED);

  // R1: a two-cycle completion follows an unflushed, uncompleted start
  p_multi_after_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_is_multi(op_i, TERN_EN)) |->
      ($past(start_i) && !$past(flush_i) && !$past(done_o)));

  // R1: a two-cycle op never completes in two consecutive cycles
  p_no_back_to_back_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_is_multi(op_i, TERN_EN)) |=> !(done_o && op_is_multi(op_i, TERN_EN)));

  // R2: single-cycle ops complete immediately
  p_single_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !flush_i && !op_is_multi(op_i, TERN_EN)) |-> done_o);

  // R3: flush silences completion
  p_flush_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !done_o);

  // R3: the cycle after a flush is a first cycle
  p_flush_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !(done_o && op_is_multi(op_i, TERN_EN)));

  // R5: or-combine keeps every input bit
  p_gorc_cover_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ((op_i == OP_GORC) || (op_i == OP_GORCI))) |->
      ((result_o & rs1_i) == rs1_i));

  // R7: conditional move with held operands
  p_cmov_pick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (TERN_EN && done_o && (op_i == OP_CMOV) && $stable(op_i) &&
     $stable(rs1_i) && $stable(rs2_i) && $stable(rs3_i)) |->
      (result_o == ((rs2_i != '0) ? rs1_i : rs3_i)));

  // R11: unassigned codes return zero
  p_unknown_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !op_is_known(op_i, TERN_EN)) |-> (result_o == '0));

endmodule

bind bmu_unit bmu_unit_checker #(.LEVEL(LEVEL), .WIDTH(WIDTH), .SH_W(SH_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .flush_i  (flush_i),
  .start_i  (start_i),
  .op_i     (op_i),
  .rs1_i    (rs1_i),
  .rs2_i    (rs2_i),
  .rs3_i    (rs3_i),
  .imm_i    (imm_i),
  .result_o (result_o),
  .done_o   (done_o)
);

// File: tb/bmu_unit_bench.sv
`timescale 1ns/1ps
module bmu_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush, start;
  logic [4:0]  op;
  logic [31:0] rs1, rs2, rs3;
  logic [5:0]  imm;
  logic [31:0] res, core_res;
  logic        done, core_done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  bmu_unit u_bmu_unit (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .start_i(start), .op_i(op),
    .rs1_i(rs1), .rs2_i(rs2), .rs3_i(rs3), .imm_i(imm),
    .result_o(res), .done_o(done)
  );

  bmu_unit #(.LEVEL(bmu_pkg::LVL_CORE)) u_bmu_unit_core (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .start_i(start), .op_i(op),
    .rs1_i(rs1), .rs2_i(rs2), .rs3_i(rs3), .imm_i(imm),
    .result_o(core_res), .done_o(core_done)
  );

  function automatic logic [31:0] nxt();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_perm(input logic [31:0] x, input logic [4:0] k, input bit orm);
    logic [31:0] m [5] = '{32'h5555_5555, 32'h3333_3333, 32'h0F0F_0F0F, 32'h00FF_00FF, 32'h0000_FFFF};
    logic [31:0] v = x;
    for (int i = 0; i < 5; i++) begin
      if (k[i]) begin
        logic [31:0] sw;
        sw = ((v & m[i]) << (1 << i)) | ((v & ~m[i]) >> (1 << i));
        v = orm ? (v | sw) : sw;
      end
    end
    return v;
  endfunction

  function automatic logic [31:0] ref_rotr(input logic [31:0] x, input logic [4:0] n);
    logic [63:0] d = {x, x} >> n;
    return d[31:0];
  endfunction

  function automatic logic [31:0] ref_funnel(input logic [31:0] a, input logic [31:0] b,
                                             input logic [5:0] s, input bit left);
    logic [31:0] hi = s[5] ? b : a;
    logic [31:0] lo = s[5] ? a : b;
    logic [63:0] t;
    if (left) begin
      t = {hi, lo} << s[4:0];
      return t[63:32];
    end
    t = {lo, hi} >> s[4:0];
    return t[31:0];
  endfunction

  function automatic logic [31:0] model(input logic [4:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] c,
                                        input logic [5:0] im);
    case (o)
      5'd0:  return a & ~b;
      5'd1:  return a | ~b;
      5'd2:  return ~(a ^ b);
      5'd3:  return a | (32'd1 << b[4:0]);
      5'd4:  return a & ~(32'd1 << b[4:0]);
      5'd5:  return a ^ (32'd1 << b[4:0]);
      5'd6:  return (a >> b[4:0]) & 32'd1;
      5'd7:  return ref_perm(a, b[4:0], 1'b0);
      5'd8:  return ref_perm(a, im[4:0], 1'b0);
      5'd9:  return ref_perm(a, b[4:0], 1'b1);
      5'd10: return ref_perm(a, im[4:0], 1'b1);
      5'd11: return ref_rotr(a, b[4:0]);
      5'd12: return ref_rotr(a, im[4:0]);
      5'd13: return ref_rotr(a, 5'd0 - b[4:0]);
      5'd14: return (b != 0) ? a : c;
      5'd15: return (a & b) | (c & ~b);
      5'd16: return ref_funnel(a, c, b[5:0], 1'b1);
      5'd17: return ref_funnel(a, c, b[5:0], 1'b0);
      5'd18: return ref_funnel(a, c, im, 1'b0);
      default: return 32'd0;
    endcase
  endfunction

  task automatic run_op(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] c, input logic [5:0] im, input string req);
    logic [31:0] exp = model(o, a, b, c, im);
    bit two = (o >= 5'd11) && (o <= 5'd18);
    @(negedge clk);
    start = 1'b1; flush = 1'b0; op = o; rs1 = a; rs2 = b; rs3 = c; imm = im;
    #0.5;
    if (o >= 5'd14 && o <= 5'd18)
      chk(core_done === 1'b1 && core_res === 32'd0, "R11 core-level three-operand code", core_res, 32'd0);
    if (two) begin
      chk(done === 1'b0, "R1 no done in first cycle", {31'd0, done}, 32'd0);
      @(negedge clk);
      #0.5;
      chk(done === 1'b1, "R1 done in second cycle", {31'd0, done}, 32'd1);
    end else begin
      chk(done === 1'b1, "R2 single-cycle done", {31'd0, done}, 32'd1);
    end
    chk(res === exp, req, res, exp);
  endtask

  task automatic idle();
    @(negedge clk);
    start = 1'b0; flush = 1'b0;
  endtask

  initial begin
    logic [31:0] pats [4];
    rst_n = 1'b0; flush = 1'b0; start = 1'b0; op = '0;
    rs1 = '0; rs2 = '0; rs3 = '0; imm = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #0.5;
    chk(done === 1'b0 && core_done === 1'b0, "R2 reset state idle", {31'd0, done}, 32'd0);

    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h8000_0001; pats[3] = nxt();

    // R9 negated logic
    for (int i = 0; i < 16; i++) begin
      logic [31:0] a = (i < 4) ? pats[i] : nxt();
      logic [31:0] b = (i % 2 == 0) ? nxt() : pats[i % 4];
      run_op(5'd0, a, b, nxt(), 6'd0, "R9 andn");
      run_op(5'd1, a, b, nxt(), 6'd0, "R9 orn");
      run_op(5'd2, a, b, nxt(), 6'd0, "R9 xnor");
    end

    // R10 every bit index, upper index bits set to show they are ignored
    for (int k = 0; k < 32; k++) begin
      logic [31:0] a = nxt();
      logic [31:0] b = {nxt() & 32'hFFFF_FFE0} | k;
      run_op(5'd3, a, b, 32'd0, 6'd0, "R10 set bit");
      run_op(5'd4, a, b, 32'd0, 6'd0, "R10 clear bit");
      run_op(5'd5, a, b, 32'd0, 6'd0, "R10 invert bit");
      run_op(5'd6, a, b, 32'd0, 6'd0, "R10 extract bit");
    end

    // R4 / R5 exhaustive control words
    for (int k = 0; k < 32; k++) begin
      for (int p = 0; p < 4; p++) begin
        run_op(5'd7,  pats[p], k, 32'd0, 6'd0,          "R4 grev reg control");
        run_op(5'd8,  pats[p], nxt(), 32'd0, 6'(k),     "R4 grev imm control");
        run_op(5'd9,  pats[p], k, 32'd0, 6'd0,          "R5 gorc reg control");
        run_op(5'd10, pats[p], nxt(), 32'd0, 6'(k + 32), "R5 gorc imm control");
      end
      pats[3] = nxt();
    end

    // R6 rotates, every amount; high amount bits random
    for (int n = 0; n < 32; n++) begin
      for (int p = 1; p < 4; p++) begin
        run_op(5'd11, pats[p], (nxt() & 32'hFFFF_FFE0) | n, 32'd0, 6'd0,  "R6 rotate right reg");
        run_op(5'd12, pats[p], nxt(), 32'd0, {nxt() % 2 == 0, 5'(n)},     "R6 rotate right imm");
        run_op(5'd13, pats[p], (nxt() & 32'hFFFF_FFE0) | n, 32'd0, 6'd0,  "R6 rotate left");
      end
      pats[3] = nxt();
    end

    // R7 conditional move and mix
    run_op(5'd14, 32'hAAAA_5555, 32'd0, 32'h1234_5678, 6'd0, "R7 cmov zero selector");
    run_op(5'd14, 32'hAAAA_5555, 32'h8000_0000, 32'h1234_5678, 6'd0, "R7 cmov nonzero selector");
    run_op(5'd15, 32'hFFFF_FFFF, 32'd0, 32'h0F0F_0F0F, 6'd0, "R7 cmix all-zero mask");
    run_op(5'd15, 32'h1357_9BDF, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 6'd0, "R7 cmix all-one mask");
    for (int i = 0; i < 24; i++) begin
      run_op(5'd14, nxt(), (i % 3 == 0) ? 32'd0 : nxt(), nxt(), 6'd0, "R7 cmov random");
      run_op(5'd15, nxt(), nxt(), nxt(), 6'd0, "R7 cmix random");
    end

    // R8 funnel shifts, every amount 0..63
    for (int s = 0; s < 64; s++) begin
      logic [31:0] a = nxt();
      logic [31:0] c = nxt();
      run_op(5'd16, a, (nxt() & 32'hFFFF_FFC0) | s, c, 6'd0, "R8 funnel left");
      run_op(5'd17, a, (nxt() & 32'hFFFF_FFC0) | s, c, 6'd0, "R8 funnel right");
      run_op(5'd18, a, nxt(), c, 6'(s),                       "R8 funnel right imm");
    end

    // R11 unassigned codes
    run_op(5'd19, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'h3F, "R11 code 19 zero");
    run_op(5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'h3F, "R11 code 31 zero");
    idle();

    // R3 flush in second cycle, then restart counts a fresh first cycle
    @(negedge clk);
    start = 1'b1; op = 5'd11; rs1 = 32'hDEAD_BEEF; rs2 = 32'd4; rs3 = 32'd0;
    @(negedge clk);
    flush = 1'b1;
    #0.5;
    chk(done === 1'b0, "R3 flush suppresses done", {31'd0, done}, 32'd0);
    @(negedge clk);
    flush = 1'b0;
    #0.5;
    chk(done === 1'b0, "R3 first cycle after flush", {31'd0, done}, 32'd0);
    @(negedge clk);
    #0.5;
    chk(done === 1'b1 && res === 32'hFDEA_DBEE, "R3 completes after restart", res, 32'hFDEA_DBEE);

    // R3 flush in first cycle of a three-operand op
    @(negedge clk);
    op = 5'd16; rs1 = 32'h1111_2222; rs2 = 32'd40; rs3 = 32'h3333_4444; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    #0.5;
    chk(done === 1'b0, "R3 first-cycle flush leaves op in first cycle", {31'd0, done}, 32'd0);
    @(negedge clk);
    #0.5;
    chk(done === 1'b1 && res === ref_funnel(32'h1111_2222, 32'h3333_4444, 6'd40, 1'b1),
        "R3 R8 result after first-cycle flush", res,
        ref_funnel(32'h1111_2222, 32'h3333_4444, 6'd40, 1'b1));
    idle();

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule